// File: doc/BRIEF.md
# Error-Corrected Word Store Controller with Byte Merge

This controller sits between one requester and a main store of 64-bit words. Each stored word is kept as a 72-bit codeword: 64 data bits, seven Hamming check bits and one overall parity bit. A requester can read a whole word, write a whole word, or write one byte. A single-bit error in a word read from the store is corrected and flagged. A double-bit error is flagged as uncorrectable and is never treated as corrected.

A byte write reads the whole word, corrects it, puts the new byte into the corrected word, re-encodes the result and writes it back. The read-back can hit an uncorrectable error. In that case the write-back is dropped, so a bad word is never overwritten with a fresh code that would hide the damage.

The store is four sub-stores, and the bench models them as plain synchronous RAMs. A configuration input chooses how word addresses are spread across the sub-stores: interleaved, or in contiguous ranges. The address space is also split into logical blocks, each with a good mark. Any access to a block marked bad is refused.

Top module: `ecc_partial_write_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_en is 0.
- R2: A full-word write stores the codeword {overall parity, check[6:0], data[63:0]}. Data occupies bits 63:0, and the XOR of all 72 stored bits is 0.
- R3: A read returns the stored data with all flags 0.
- R4: A word with one flipped bit is returned corrected with rsp_sbe=1 and rsp_mbe=0. This holds whether the flipped bit is a data bit, a check bit (bits 70:64) or the parity bit (bit 71).
- R5: A word with two flipped bits is reported with rsp_mbe=1 and rsp_sbe=0.
- R6: A byte write (req_op=2) replaces byte lane req_byte_sel, which is bits 8*lane+7 to 8*lane, with req_wdata[7:0]. Every other byte keeps its value, and bits 63:8 of req_wdata are ignored.
- R7: A byte write onto a word that holds a single-bit error merges into the corrected data and writes back a clean codeword. Its response carries rsp_sbe=1.
- R8: A byte write whose read phase finds an uncorrectable error leaves the stored word unchanged and responds with rsp_mbe=1.
- R9: With cfg_interleave=1, the sub-store is addr[1:0] and the index is addr[7:2]. With cfg_interleave=0, the sub-store is addr[7:6] and the index is addr[5:0].
- R10: The block number is addr[7:6]. A request to a block whose blk_good bit is 0 responds with rsp_bad=1 and rsp_rdata=0, and issues no store access.
- R11: The response arrives a fixed number of rising edges after the accepting edge. That count is 0 for a bad block, 1 for a full write, 2 for a read or an aborted byte write, and 3 for a byte write. req_ready is 0 while an access is in progress. req_op values are 0 for read, 1 for full write, 2 for byte write, and 3 behaves as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interleave | input | 1 | 1 selects interleaved sub-store mapping |
| blk_good | input | 4 | One good mark per logical block |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | Operation code |
| req_addr | input | 8 | Word address |
| req_byte_sel | input | 3 | Byte lane for a byte write |
| req_wdata | input | 64 | Write data (byte write uses bits 7:0) |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Corrected read data |
| rsp_sbe | output | 1 | Single-bit error corrected |
| rsp_mbe | output | 1 | Uncorrectable error |
| rsp_bad | output | 1 | Access to a block marked bad |
| mem_en | output | 1 | Store access enable |
| mem_we | output | 1 | Store write enable |
| mem_sub | output | 2 | Sub-store select |
| mem_idx | output | 6 | Word index within the sub-store |
| mem_wcode | output | 72 | Codeword to write |
| mem_rcode | input | 72 | Codeword read, valid one cycle after a read enable |

## Verification
The assertions check on every cycle the links between the decoder and the response port:
- a bad-block request never reaches the store;
- an uncorrectable read-back during a byte write suppresses the write-back and raises rsp_mbe;
- corrected data and flags travel unchanged to the response;
- the controller drops req_ready once it accepts a real access.

Only the bench scenarios can show the rest. These are the exact codeword layout, correction of each class of flipped bit, the merged byte landing in the right lane, the stored word left unchanged after an abort, and both address mappings. The bench shows these by injecting faults straight into its RAM model and reading the words back.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 7;
  localparam int CODE_W = DATA_W + CHK_W + 1;
  localparam int DI_W   = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_BW  = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD1  = 2'd1,
    S_RD2  = 2'd2,
    S_WR   = 2'd3
  } state_e;

  // Hamming check bits: each data bit sits at a codeword position that is
  // not a power of two (3,5,6,7,9,...); check bit k covers positions with bit k set.
  function automatic logic [CHK_W-1:0] calc_chk(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < CHK_W; k++) begin
          if (((p >> k) & 1) != 0) c = c ^ (CHK_W'(d[di[DI_W-1:0]]) << k);
        end
        di++;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/pwc_ecc_enc.sv
module pwc_ecc_enc
  import pwc_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [CHK_W-1:0] chk;

  always_comb begin
    chk  = calc_chk(data);
    code = {^{chk, data}, chk, data};
  end
endmodule

// File: rtl/pwc_ecc_dec.sv
module pwc_ecc_dec
  import pwc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic              sbe,
  output logic              mbe
);
  logic [CHK_W-1:0] syn;
  logic             par;
  int               di;

  always_comb begin
    syn  = calc_chk(code[DATA_W-1:0]) ^ code[DATA_W +: CHK_W];
    par  = ^code;
    data = code[DATA_W-1:0];
    di   = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (32'(syn) == p) data = data ^ (DATA_W'(1) << di[DI_W-1:0]);
        di++;
      end
    end
    sbe = par && (32'(syn) < CODE_W);
    mbe = (!par && syn != '0) || (par && 32'(syn) >= CODE_W);
  end
endmodule

// File: rtl/pwc_addr_map.sv
module pwc_addr_map #(
  parameter int ADDR_W = 8,
  parameter int SUB_W  = 2,
  localparam int IDX_W = ADDR_W - SUB_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  output logic [SUB_W-1:0]  sub,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    if (interleave) begin
      sub = addr[SUB_W-1:0];
      idx = addr[ADDR_W-1:SUB_W];
    end else begin
      sub = addr[ADDR_W-1 -: SUB_W];
      idx = addr[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/ecc_partial_write_ctrl.sv
module ecc_partial_write_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SUB = 4,
  parameter int NUM_BLK = 4,
  localparam int SUB_W  = $clog2(NUM_SUB),
  localparam int IDX_W  = ADDR_W - SUB_W,
  localparam int BLK_W  = $clog2(NUM_BLK),
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_interleave,
  input  logic [NUM_BLK-1:0] blk_good,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANE_W-1:0]  req_byte_sel,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_sbe,
  output logic               rsp_mbe,
  output logic               rsp_bad,
  output logic               mem_en,
  output logic               mem_we,
  output logic [SUB_W-1:0]   mem_sub,
  output logic [IDX_W-1:0]   mem_idx,
  output logic [CODE_W-1:0]  mem_wcode,
  input  logic [CODE_W-1:0]  mem_rcode
);
  state_e             state;
  op_e                op_q;
  logic [LANE_W-1:0]  bsel_q;
  logic [7:0]         byte_q;
  logic               sbe_pend;
  logic [SUB_W-1:0]   map_sub;
  logic [IDX_W-1:0]   map_idx;
  logic [BLK_W-1:0]   req_blk;
  logic [DATA_W-1:0]  dec_data;
  logic               dec_sbe;
  logic               dec_mbe;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  enc_in;
  logic [CODE_W-1:0]  enc_code;

  assign req_blk   = req_addr[ADDR_W-1 -: BLK_W];
  assign req_ready = (state == S_IDLE);

  pwc_addr_map #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_map (
    .addr(req_addr), .interleave(cfg_interleave), .sub(map_sub), .idx(map_idx)
  );

  pwc_ecc_dec u_dec (
    .code(mem_rcode), .data(dec_data), .sbe(dec_sbe), .mbe(dec_mbe)
  );

  // Byte merge into the corrected word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = (bsel_q == LANE_W'(g)) ? byte_q : dec_data[g*8 +: 8];
  end

  assign enc_in = (state == S_IDLE) ? req_wdata : merged;

  pwc_ecc_enc u_enc (.data(enc_in), .code(enc_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_RD;
      bsel_q    <= '0;
      byte_q    <= '0;
      sbe_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_sbe   <= 1'b0;
      rsp_mbe   <= 1'b0;
      rsp_bad   <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_sub   <= '0;
      mem_idx   <= '0;
      mem_wcode <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q     <= op_e'(req_op);
            bsel_q   <= req_byte_sel;
            byte_q   <= req_wdata[7:0];
            sbe_pend <= 1'b0;
            mem_sub  <= map_sub;
            mem_idx  <= map_idx;
            if (!blk_good[req_blk]) begin
              rsp_valid <= 1'b1;
              rsp_bad   <= 1'b1;
              rsp_sbe   <= 1'b0;
              rsp_mbe   <= 1'b0;
              rsp_rdata <= '0;
            end else if (op_e'(req_op) == OP_WR) begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_wcode <= enc_code;
              state     <= S_WR;
            end else begin
              mem_en <= 1'b1;
              mem_we <= 1'b0;
              state  <= S_RD1;
            end
          end
        end
        S_RD1: begin
          mem_en <= 1'b0;
          state  <= S_RD2;
        end
        S_RD2: begin
          if (op_q == OP_BW && !dec_mbe) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wcode <= enc_code;
            sbe_pend  <= dec_sbe;
            state     <= S_WR;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= (op_q == OP_BW) ? '0 : dec_data;
            rsp_sbe   <= dec_sbe;
            rsp_mbe   <= dec_mbe;
            rsp_bad   <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: begin
          mem_en    <= 1'b0;
          mem_we    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          rsp_sbe   <= sbe_pend;
          rsp_mbe   <= 1'b0;
          rsp_bad   <= 1'b0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  // R10
  bad_blk_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && req_valid && !blk_good[req_blk]) |=> (rsp_valid && rsp_bad && !mem_en));

  // R8
  abort_on_mbe_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD2 && op_q == OP_BW && dec_mbe) |=> (!mem_en && rsp_valid && rsp_mbe));

  // R5
  mbe_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD2 && op_q != OP_BW && dec_mbe) |=> (rsp_valid && rsp_mbe && !rsp_sbe));

  // R4
  sbe_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_RD2 && op_q != OP_BW && dec_sbe) |=> (rsp_sbe && rsp_rdata == $past(dec_data)));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && blk_good[req_blk]) |=> !req_ready);
endmodule

// File: tb/tb_ecc_partial_write_ctrl.sv
module tb_ecc_partial_write_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_interleave = 1'b1;
  logic [3:0]  blk_good = 4'hF;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_byte_sel = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_sbe, rsp_mbe, rsp_bad;
  logic [63:0] rsp_rdata;
  logic        mem_en, mem_we;
  logic [1:0]  mem_sub;
  logic [5:0]  mem_idx;
  logic [71:0] mem_wcode;
  logic [71:0] mem_rcode;

  logic [71:0] ram [4][64];
  logic        inj_en = 1'b0;
  logic [1:0]  inj_sub = '0;
  logic [5:0]  inj_idx = '0;
  logic [71:0] inj_mask = '0;
  int          mem_cnt = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  ecc_partial_write_ctrl dut (
    .clk(clk), .rst(rst), .cfg_interleave(cfg_interleave), .blk_good(blk_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
    .req_byte_sel(req_byte_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_sbe(rsp_sbe), .rsp_mbe(rsp_mbe), .rsp_bad(rsp_bad),
    .mem_en(mem_en), .mem_we(mem_we), .mem_sub(mem_sub), .mem_idx(mem_idx),
    .mem_wcode(mem_wcode), .mem_rcode(mem_rcode)
  );

  // Behavioural sub-store RAMs with fault injection port
  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 64; i++) ram[s][i] <= '0;
      mem_rcode <= '0;
    end else begin
      if (mem_en) begin
        mem_cnt <= mem_cnt + 1;
        if (mem_we) ram[mem_sub][mem_idx] <= mem_wcode;
        else        mem_rcode <= ram[mem_sub][mem_idx];
      end
      if (inj_en) ram[inj_sub][inj_idx] <= ram[inj_sub][inj_idx] ^ inj_mask;
    end
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic inject(input int s, input int i, input logic [71:0] m);
    @(negedge clk);
    inj_sub = 2'(s); inj_idx = 6'(i); inj_mask = m; inj_en = 1'b1;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] addr, input logic [2:0] bsel,
                       input logic [63:0] wd, output logic [63:0] rd,
                       output logic [2:0] fl, output int lat, output logic rdy_after);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_byte_sel = bsel; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_after = req_ready;
    lat = 0;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    fl = {rsp_bad, rsp_mbe, rsp_sbe};
  endtask

  // {op, addr, bsel, wdata, expected rdata, expected {bad,mbe,sbe}}
  localparam logic [143:0] TBL [9] = '{
    {2'd1, 8'd5,   3'd0, 64'h0123_4567_89AB_CDEF, 64'h0, 3'b000},
    {2'd1, 8'd9,   3'd0, 64'hFEDC_BA98_7654_3210, 64'h0, 3'b000},
    {2'd0, 8'd5,   3'd0, 64'h0, 64'h0123_4567_89AB_CDEF, 3'b000},
    {2'd2, 8'd5,   3'd3, 64'hFFFF_FFFF_FFFF_FF5A, 64'h0, 3'b000},
    {2'd0, 8'd5,   3'd0, 64'h0, 64'h0123_4567_5AAB_CDEF, 3'b000},
    {2'd2, 8'd9,   3'd7, 64'hAAAA_AAAA_AAAA_AAC3, 64'h0, 3'b000},
    {2'd3, 8'd9,   3'd0, 64'h0, 64'hC3DC_BA98_7654_3210, 3'b000},
    {2'd2, 8'd200, 3'd0, 64'h0000_0000_0000_0077, 64'h0, 3'b000},
    {2'd0, 8'd200, 3'd0, 64'h0, 64'h0000_0000_0000_0077, 3'b000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [2:0]  fl;
    int          lat;
    logic        ra;
    logic [71:0] w0;
    int          mc;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 72'(req_ready), 72'd1);
    chk("R1 rsp_valid", 72'(rsp_valid), 72'd0);
    chk("R1 mem_en", 72'(mem_en), 72'd0);

    // Table walk: R3 reads, R6 byte writes, R11 latency
    for (int i = 0; i < 9; i++) begin
      logic [143:0] v;
      int el;
      v = TBL[i];
      do_op(v[143:142], v[141:134], v[133:131], v[130:67], rd, fl, lat, ra);
      el = (v[143:142] == 2'd1) ? 1 : (v[143:142] == 2'd2) ? 3 : 2;
      chk($sformatf("R3/R6 data vec%0d", i), 72'(rd), 72'(v[66:3]));
      chk($sformatf("R3 flags vec%0d", i), 72'(fl), 72'(v[2:0]));
      chk($sformatf("R11 latency vec%0d", i), 72'(lat), 72'(el));
      chk($sformatf("R11 ready busy vec%0d", i), 72'(ra), 72'd0);
    end

    // R2 codeword layout and parity (addr 9 interleaved -> sub 1, idx 2)
    chk("R2 data field", 72'(ram[1][2][63:0]), 72'(64'hC3DC_BA98_7654_3210));
    chk("R2 even parity", 72'(^ram[1][2]), 72'd0);

    // R4 single-bit correction: data bit, check bit, parity bit
    inject(1, 2, 72'(1) << 10);
    do_op(2'd0, 8'd9, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R4 data-bit data", 72'(rd), 72'(64'hC3DC_BA98_7654_3210));
    chk("R4 data-bit flags", 72'(fl), 72'b001);
    inject(1, 2, 72'(1) << 10);
    inject(1, 2, 72'(1) << 66);
    do_op(2'd0, 8'd9, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R4 check-bit data", 72'(rd), 72'(64'hC3DC_BA98_7654_3210));
    chk("R4 check-bit flags", 72'(fl), 72'b001);
    inject(1, 2, 72'(1) << 66);
    inject(1, 2, 72'(1) << 71);
    do_op(2'd0, 8'd9, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R4 parity-bit data", 72'(rd), 72'(64'hC3DC_BA98_7654_3210));
    chk("R4 parity-bit flags", 72'(fl), 72'b001);
    inject(1, 2, 72'(1) << 71);

    // R5 double-bit detection
    inject(1, 2, (72'(1) << 3) | (72'(1) << 40));
    do_op(2'd0, 8'd9, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R5 flags", 72'(fl), 72'b010);

    // R8 byte write aborted on uncorrectable read-back
    w0 = ram[1][2];
    do_op(2'd2, 8'd9, 3'd0, 64'hAA, rd, fl, lat, ra);
    chk("R8 flags", 72'(fl), 72'b010);
    chk("R8 latency", 72'(lat), 72'd2);
    chk("R8 word unchanged", ram[1][2], w0);
    inject(1, 2, (72'(1) << 3) | (72'(1) << 40));

    // R7 byte write merges into corrected data
    inject(1, 2, 72'(1) << 20);
    do_op(2'd2, 8'd9, 3'd1, 64'h11, rd, fl, lat, ra);
    chk("R7 flags", 72'(fl), 72'b001);
    chk("R7 stored data", 72'(ram[1][2][63:0]), 72'(64'hC3DC_BA98_7654_1110));
    chk("R7 stored parity", 72'(^ram[1][2]), 72'd0);
    do_op(2'd0, 8'd9, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R7 readback data", 72'(rd), 72'(64'hC3DC_BA98_7654_1110));
    chk("R7 readback flags", 72'(fl), 72'b000);

    // R9 non-interleaved mapping: addr 0x47 -> sub 1, idx 7
    cfg_interleave = 1'b0;
    do_op(2'd1, 8'h47, 3'd0, 64'h1111_2222_3333_4444, rd, fl, lat, ra);
    chk("R9 contiguous slot", 72'(ram[1][7][63:0]), 72'(64'h1111_2222_3333_4444));
    chk("R9 interleaved slot untouched", 72'(ram[3][17][63:0]), 72'd0);
    do_op(2'd0, 8'h47, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R9 readback", 72'(rd), 72'(64'h1111_2222_3333_4444));

    // R10 bad block (block 1) refused without store access
    blk_good = 4'b1101;
    mc = mem_cnt;
    do_op(2'd0, 8'h47, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R10 read flags", 72'(fl), 72'b100);
    chk("R10 read data", 72'(rd), 72'd0);
    chk("R10 latency", 72'(lat), 72'd0);
    do_op(2'd1, 8'h50, 3'd0, 64'hDEAD_BEEF_0000_0001, rd, fl, lat, ra);
    chk("R10 write flags", 72'(fl), 72'b100);
    chk("R10 no store access", 72'(mem_cnt - mc), 72'd0);
    chk("R10 word unwritten", ram[1][16], 72'd0);
    blk_good = 4'hF;
    do_op(2'd0, 8'h47, 3'd0, 64'h0, rd, fl, lat, ra);
    chk("R10 block intact", 72'(rd), 72'(64'h1111_2222_3333_4444));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule